// File: doc/BRIEF.md
# Supply-loss protection sequencer

This block sits between two digitized supply comparators and the protection pins of a battery-backed memory controller. One input says the main supply has dropped under the deselect threshold. The other says the supply has dropped under the battery voltage. From these two inputs the block drives five outputs:

- a write inhibit for the bus controller;
- an active-low system reset;
- a force-high for the external RAM chip enable;
- a battery-select strobe;
- an output enable for the general-purpose pins.

Both inputs are first synchronized to the free-running clock and then debounced, so a short spike on a comparator is never acted on. A loss of supply moves the block into protection. A deeper loss moves it onto the battery. In battery mode the general outputs float and only the RAM enable, reset and related pins stay driven. When the supply comes back, protection is held for a fixed number of clock cycles before it is released. A new dip during that hold restarts the hold from the beginning. The block starts up in protection after reset, so power-on gets the same hold as a recovery.

Top module: `pwr_guard_seq`

## Requirements
- R1: While rst_ni is low, the outputs are in the protect pattern: wr_inhibit_o=1, rst_no=0, ram_ce_force_o=1, bat_sel_o=0, gen_oe_o=1. After reset is released with both supply inputs low, all three protection outputs are released within HOLD_CYCLES to HOLD_CYCLES+SYNC_STAGES+DEB_CYCLES+2 cycles.
- R2: A steady high on below_pfd_i drives the protect pattern within SYNC_STAGES+DEB_CYCLES+1 cycles, and no sooner than DEB_CYCLES cycles.
- R3: A steady high on below_bat_i drives the battery pattern. In that pattern bat_sel_o=1 and gen_oe_o=0, while wr_inhibit_o=1, rst_no=0 and ram_ce_force_o=1 are kept.
- R4: If below_bat_i clears while below_pfd_i stays high, the outputs return to the protect pattern. Protection is not released in this case.
- R5: Once both supply inputs are low, protection is held for a total of HOLD_CYCLES+DEB_CYCLES to HOLD_CYCLES+SYNC_STAGES+DEB_CYCLES+1 cycles. Write inhibit, reset and chip-enable force are then released in the same cycle. This holds whether the block was in protect or in battery.
- R6: A high on either supply input that lasts at least DEB_CYCLES cycles during the recovery hold restarts the hold. Release then happens no earlier than HOLD_CYCLES cycles after that input clears.
- R7: A high on either supply input shorter than DEB_CYCLES cycles has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| below_pfd_i | input | 1 | Supply under deselect threshold (asynchronous) |
| below_bat_i | input | 1 | Supply under battery level (asynchronous) |
| wr_inhibit_o | output | 1 | Write inhibit to the bus controller |
| rst_no | output | 1 | Active-low system reset |
| ram_ce_force_o | output | 1 | Forces the external RAM chip enable high |
| bat_sel_o | output | 1 | Selects battery as the supply |
| gen_oe_o | output | 1 | Output enable of the general-purpose pins |

## Verification
A wrong sequencer state shows up at the ports as one of the three output patterns appearing in the wrong place. The most harmful case is the normal pattern appearing while an input is still asserted, or before the hold has run out. Any such error becomes visible one clock after the filtered input changes. A hold counter that is not cleared on a dip shows up only at release time, as a release that comes too early. For this reason the bench times every release from the last input edge, not just from the state change. Filter errors show up either as a short spike changing the outputs, or as a response latency outside the synchronizer-plus-debounce window.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } guard_state_e;

  localparam int unsigned IDX_PFD = 0;
  localparam int unsigned IDX_BAT = 1;
  localparam int unsigned N_SUPPLY = 2;
endpackage

// File: rtl/pwr_sync_filt.sv
module pwr_sync_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4,
  parameter logic        RST_VAL     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   flt_q;
  logic                   smp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {SYNC_STAGES{RST_VAL}};
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign smp = sync_q[SYNC_STAGES-1];

  // flip only after DEB_CYCLES consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      flt_q <= RST_VAL;
    end else if (smp == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
      cnt_q <= '0;
      flt_q <= smp;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 6554
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == CW'(HOLD_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pfd_i,
  input  logic         bat_i,
  input  logic         hold_done_i,
  output guard_state_e state_o
);
  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (bat_i)      state_d = ST_BATTERY;
        else if (pfd_i) state_d = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (bat_i)       state_d = ST_BATTERY;
        else if (!pfd_i) state_d = ST_RECOVER;
      end
      ST_BATTERY: begin
        if (!bat_i) state_d = pfd_i ? ST_PROTECT : ST_RECOVER;
      end
      ST_RECOVER: begin
        if (bat_i)            state_d = ST_BATTERY;
        else if (pfd_i)       state_d = ST_PROTECT;
        else if (hold_done_i) state_d = ST_NORMAL;
      end
      default: state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PROTECT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYCLES  = 4,
  parameter int unsigned HOLD_CYCLES = 6554
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_pfd_i,
  input  logic below_bat_i,
  output logic wr_inhibit_o,
  output logic rst_no,
  output logic ram_ce_force_o,
  output logic bat_sel_o,
  output logic gen_oe_o
);
  logic [N_SUPPLY-1:0] raw, flt;
  guard_state_e        state;
  logic                hold_done;

  assign raw[IDX_PFD] = below_pfd_i;
  assign raw[IDX_BAT] = below_bat_i;

  for (genvar g = 0; g < N_SUPPLY; g++) begin : g_filt
    pwr_sync_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .flt_o (flt[g])
    );
  end

  pwr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state == ST_RECOVER),
    .done_o(hold_done)
  );

  pwr_guard_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pfd_i      (flt[IDX_PFD]),
    .bat_i      (flt[IDX_BAT]),
    .hold_done_i(hold_done),
    .state_o    (state)
  );

  assign wr_inhibit_o   = (state != ST_NORMAL);
  assign rst_no         = (state == ST_NORMAL);
  assign ram_ce_force_o = (state != ST_NORMAL);
  assign bat_sel_o      = (state == ST_BATTERY);
  assign gen_oe_o       = (state != ST_BATTERY);
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk #(
  parameter int unsigned HOLD_CYCLES = 6554
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pfd_flt_i,
  input logic bat_flt_i,
  input logic wr_inhibit_i,
  input logic rst_n_i,
  input logic ram_ce_force_i,
  input logic bat_sel_i,
  input logic gen_oe_i
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] clear_cnt_q;

  // consecutive cycles with both filtered supply flags clear, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               clear_cnt_q <= '0;
    else if (pfd_flt_i || bat_flt_i)           clear_cnt_q <= '0;
    else if (clear_cnt_q != CW'(HOLD_CYCLES))  clear_cnt_q <= clear_cnt_q + 1'b1;
  end

  assert_deselect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfd_flt_i |=> (wr_inhibit_i && !rst_n_i && ram_ce_force_i));

  assert_battery_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bat_flt_i |=> (bat_sel_i && !gen_oe_i && wr_inhibit_i && !rst_n_i));

  assert_battery_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bat_sel_i && !bat_flt_i && pfd_flt_i) |=> (!bat_sel_i && gen_oe_i && wr_inhibit_i));

  assert_hold_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_inhibit_i) |-> (clear_cnt_q >= CW'(HOLD_CYCLES)));

  assert_release_together_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_inhibit_i) |-> ($rose(rst_n_i) && $fell(ram_ce_force_i)));
endmodule

bind pwr_guard_seq pwr_guard_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pfd_flt_i     (flt[0]),
  .bat_flt_i     (flt[1]),
  .wr_inhibit_i  (wr_inhibit_o),
  .rst_n_i       (rst_no),
  .ram_ce_force_i(ram_ce_force_o),
  .bat_sel_i     (bat_sel_o),
  .gen_oe_i      (gen_oe_o)
);

// File: tb/pwr_guard_seq_test.sv
module pwr_guard_seq_test;
  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int HOLD = 40;

  // {wr_inhibit, rst_n, ce_force, bat_sel, gen_oe}
  localparam logic [4:0] P_NORMAL  = 5'b01001;
  localparam logic [4:0] P_PROTECT = 5'b10101;
  localparam logic [4:0] P_BATTERY = 5'b10110;

  logic clk = 0, rst_ni = 0, pfd = 0, bat = 0;
  logic wr_inh, rst_n, ce_f, bsel, goe;
  int   n_checks = 0, n_fail = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  pwr_guard_seq #(.SYNC_STAGES(SYNC), .DEB_CYCLES(DEB), .HOLD_CYCLES(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .below_pfd_i(pfd), .below_bat_i(bat),
    .wr_inhibit_o(wr_inh), .rst_no(rst_n), .ram_ce_force_o(ce_f),
    .bat_sel_o(bsel), .gen_oe_o(goe));

  wire [4:0] outs = {wr_inh, rst_n, ce_f, bsel, goe};

  function automatic logic [4:0] expect_pat(bit p, bit b);
    if (b) return P_BATTERY;
    if (p) return P_PROTECT;
    return P_NORMAL;
  endfunction

  task automatic chk_pat(string req, logic [4:0] exp_v);
    n_checks++;
    if (outs !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, outs, exp_v);
    end
  endtask

  task automatic chk_rng(string req, int val, int lo, int hi);
    n_checks++;
    if (val < lo || val > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, val, lo, hi);
    end
  endtask

  task automatic wait_pat(logic [4:0] exp_v, int limit, output int n);
    n = 0;
    while (outs !== exp_v && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    int sel, len;
    bit bad;
    void'($urandom(32'h5eed_1234));
    cycles(3);
    chk_pat("R1 reset pattern", P_PROTECT);
    rst_ni = 1;
    wait_pat(P_NORMAL, HOLD + 50, n);
    chk_rng("R1 power-on hold", n, HOLD, HOLD + SYNC + DEB + 2);
    chk_pat("R1 normal after hold", P_NORMAL);

    // R7: short spikes on random inputs
    for (int i = 0; i < 10; i++) begin
      sel = $urandom_range(0, 2);
      len = $urandom_range(1, DEB - 1);
      if (sel != 1) pfd = 1;
      if (sel != 0) bat = 1;
      cycles(len);
      pfd = 0; bat = 0;
      bad = 0;
      for (int k = 0; k < SYNC + DEB + 4; k++) begin
        @(negedge clk);
        if (outs !== P_NORMAL) bad = 1;
      end
      n_checks++;
      if (bad) begin
        n_fail++;
        $display("FAIL R7 spike len %0d sel %0d: actual changed expected %b", len, sel, P_NORMAL);
      end
    end

    // R2 deselect latency
    pfd = 1;
    wait_pat(P_PROTECT, 50, n);
    chk_rng("R2 deselect latency", n, DEB, SYNC + DEB + 1);
    cycles(HOLD + 10);
    chk_pat("R2 protect held", expect_pat(1, 0));

    // R3 battery
    bat = 1;
    wait_pat(P_BATTERY, 50, n);
    chk_rng("R3 battery latency", n, DEB, SYNC + DEB + 1);
    cycles(20);
    chk_pat("R3 battery pattern", expect_pat(1, 1));

    // R4 leave battery with supply still low
    bat = 0;
    wait_pat(P_PROTECT, 50, n);
    chk_rng("R4 back to protect", n, DEB, SYNC + DEB + 1);
    cycles(HOLD + 10);
    chk_pat("R4 no release", P_PROTECT);

    // R5 release from protect
    pfd = 0;
    wait_pat(P_NORMAL, HOLD + 50, n);
    chk_rng("R5 release from protect", n, HOLD + DEB, HOLD + SYNC + DEB + 1);

    // R5 release from battery, both inputs together
    pfd = 1; bat = 1;
    wait_pat(P_BATTERY, 50, n);
    chk_pat("R3 both inputs", P_BATTERY);
    cycles(15);
    pfd = 0; bat = 0;
    bad = 0;
    for (int k = 0; k < HOLD + DEB - 1; k++) begin
      @(negedge clk);
      if (outs === P_NORMAL) bad = 1;
    end
    n_checks++;
    if (bad) begin
      n_fail++;
      $display("FAIL R5 early release: actual %b expected protected", outs);
    end
    wait_pat(P_NORMAL, HOLD + 50, n);
    chk_pat("R5 release from battery", P_NORMAL);

    // R6 dip during recovery restarts hold
    pfd = 1;
    wait_pat(P_PROTECT, 50, n);
    cycles(5);
    pfd = 0;
    cycles(SYNC + DEB + HOLD / 2);
    chk_pat("R6 in recovery", P_PROTECT);
    pfd = 1;
    cycles(DEB + 3);
    pfd = 0;
    wait_pat(P_NORMAL, 2 * HOLD + 50, n);
    chk_rng("R6 restarted hold", n, HOLD + DEB, HOLD + SYNC + DEB + 1);

    // R7 short dip during recovery does not restart
    pfd = 1;
    wait_pat(P_PROTECT, 50, n);
    pfd = 0;
    cycles(HOLD / 2);
    bat = 1;
    cycles(DEB - 1);
    bat = 0;
    wait_pat(P_NORMAL, 2 * HOLD + 50, n);
    chk_rng("R7 spike in recovery", n + HOLD / 2 + DEB - 1, HOLD + DEB, HOLD + SYNC + DEB + 1);

    // random long episodes
    for (int i = 0; i < 8; i++) begin
      bit rb;
      rb = $urandom_range(0, 1);
      pfd = 1; bat = rb;
      wait_pat(expect_pat(1, rb), 50, n);
      chk_rng(rb ? "R3 random entry" : "R2 random entry", n, DEB, SYNC + DEB + 1);
      cycles($urandom_range(DEB + SYNC, 3 * HOLD));
      chk_pat(rb ? "R3 random hold" : "R2 random hold", expect_pat(1, rb));
      pfd = 0; bat = 0;
      wait_pat(P_NORMAL, HOLD + 50, n);
      chk_rng("R5 random release", n, HOLD + DEB, HOLD + SYNC + DEB + 1);
      cycles($urandom_range(1, 20));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule